// File: doc/BRIEF.md
# Jump Target Address Calculator

This unit takes one decoded jump instruction and works out where execution continues next. The caller supplies several inputs:

- the opcode byte and the three-bit reg field of the ModRM byte;
- up to six immediate bytes, packed little-endian;
- the instruction length and the current instruction pointer;
- the operand-size attribute;
- a protected-mode indication;
- an operand value that the caller has already read from a register or from memory.

One clock later the unit presents a new 32-bit instruction pointer. For far forms it also presents a new 16-bit code-segment selector with a load strobe.

Short jumps with an 8-bit displacement and near jumps with a 16-bit or 32-bit displacement are relative. The unit sign-extends the displacement and adds it to the address of the following instruction. A near indirect jump loads its absolute offset straight from the operand. A far jump takes both an offset and a selector, either from the immediate bytes or from the operand. In protected mode the unit also raises an intercept flag for every far jump, because such a target might name a gate or a task. Under the 16-bit operand size, bits 31:16 of every result are forced to zero.

The unit flags any encoding it does not recognise as illegal. In that case it leaves its pointer and selector outputs unchanged. Instruction fetch, memory reads, descriptor and privilege checks, and task switching are all left to the surrounding logic.

Top module: `jump_target_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the unit clears `nextIp`, `selOut`, `outValid`, `selLoad`, `illegalFlag` and `interceptFlag` to zero.
- R2: An accepted legal jump (`inValid` high) raises `outValid` for exactly one cycle, at the next rising edge. `outValid` is never high in a cycle that does not follow an `inValid` cycle.
- R3: For opcode 0xEB, `nextIp` = `curIp` + `instLen` + the sign extension of `immBytes[7:0]`.
- R4: For opcode 0xE9, the displacement is the sign extension of `immBytes[15:0]` when `opSize32` is 0, and `immBytes[31:0]` when it is 1. It is added to `curIp` + `instLen`.
- R5: When `opSize32` is 0, bits 31:16 of `nextIp` are zero for every jump form.
- R6: For opcode 0xFF with reg field 4, `nextIp` equals `rmOperand[31:0]`, with no addition.
- R7: Near forms (0xEB, 0xE9, 0xFF reg field 4) keep `selLoad` low and leave `selOut` unchanged.
- R8: For opcode 0xEA with `opSize32` = 1, the offset is `immBytes[31:0]` and the selector is `immBytes[47:32]`. With `opSize32` = 0, the offset is `immBytes[15:0]`, zero-extended, and the selector is `immBytes[31:16]`. `selLoad` pulses together with `outValid`.
- R9: For opcode 0xFF with reg field 5, the offset and selector come from `rmOperand`, using the same bit layout as in R8.
- R10: A far jump raises `interceptFlag` together with `outValid` when `protMode` is 1. `interceptFlag` stays low for near jumps and when `protMode` is 0.
- R11: Opcode 0xFF with any reg field other than 4 or 5, and any opcode outside {0xEB, 0xE9, 0xEA, 0xFF}, raise `illegalFlag` for one cycle instead of `outValid`. `nextIp` and `selOut` keep their previous values.
- R12: Relative sums wrap modulo 2^32, or modulo 2^16 under the 16-bit operand size, and no overflow is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Instruction inputs are valid this cycle |
| opcode | input | 8 | Opcode byte |
| modrmReg | input | 3 | Reg field of the ModRM byte |
| immBytes | input | 48 | Immediate bytes, little-endian |
| instLen | input | 4 | Length of the jump instruction in bytes |
| curIp | input | 32 | Instruction pointer of the jump |
| opSize32 | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| protMode | input | 1 | Protected-mode context |
| rmOperand | input | 48 | Register or memory operand value |
| nextIp | output | 32 | Computed instruction pointer |
| selOut | output | 16 | Selector for far jumps |
| selLoad | output | 1 | Selector load strobe |
| outValid | output | 1 | Result valid strobe |
| illegalFlag | output | 1 | Unsupported encoding strobe |
| interceptFlag | output | 1 | Far jump needs an intercept |

## Verification
The assertions assume three things about the inputs: `inValid` is a clean single-cycle qualifier, `opSize32` and `protMode` are sampled only while `inValid` is high, and the operand bytes are stable for that one cycle. The bench drives every field at the falling edge, holds it for a full cycle, and then drops `inValid`, so all of these assumptions hold. The bench also issues back-to-back requests, including an illegal encoding placed between two legal jumps, to show that the held values are not disturbed by one another.

// File: rtl/jtu_pkg.sv
package jtu_pkg;
  localparam logic [7:0] OP_SHORT_REL = 8'hEB;
  localparam logic [7:0] OP_NEAR_REL  = 8'hE9;
  localparam logic [7:0] OP_FAR_IMM   = 8'hEA;
  localparam logic [7:0] OP_GROUP_FF  = 8'hFF;
  localparam logic [2:0] REG_NEAR_IND = 3'd4;
  localparam logic [2:0] REG_FAR_IND  = 3'd5;

  typedef enum logic [1:0] {
    DISP_B8  = 2'd0,
    DISP_B16 = 2'd1,
    DISP_B32 = 2'd2
  } dispSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      capture;   // legal jump accepted this cycle
    logic      isRel;     // add displacement to following address
    dispSize_e dispSize;  // displacement width
    logic      isFar;     // offset plus selector
    logic      fromImm;   // far pointer taken from immediate bytes
    logic      wide;      // 32-bit operand size
  } jtuCtrl_t;
endpackage

// File: rtl/jtu_control.sv
module jtu_control
  import jtu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [7:0] opcode,
  input  logic [2:0] modrmReg,
  input  logic       opSize32,
  input  logic       protMode,
  output jtuCtrl_t   ctrl,
  output logic       outValid,
  output logic       selLoad,
  output logic       illegalFlag,
  output logic       interceptFlag
);
  logic isShort, isNear, isFarImm, isGroup, grpNear, grpFar, legal;

  always_comb begin
    isShort  = (opcode == OP_SHORT_REL);
    isNear   = (opcode == OP_NEAR_REL);
    isFarImm = (opcode == OP_FAR_IMM);
    isGroup  = (opcode == OP_GROUP_FF);
    grpNear  = isGroup && (modrmReg == REG_NEAR_IND);
    grpFar   = isGroup && (modrmReg == REG_FAR_IND);
    legal    = isShort | isNear | isFarImm | grpNear | grpFar;

    ctrl.capture  = inValid & legal;
    ctrl.isRel    = isShort | isNear;
    ctrl.dispSize = isShort ? DISP_B8 : (opSize32 ? DISP_B32 : DISP_B16);
    ctrl.isFar    = isFarImm | grpFar;
    ctrl.fromImm  = isFarImm;
    ctrl.wide     = opSize32;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid      <= 1'b0;
      selLoad       <= 1'b0;
      illegalFlag   <= 1'b0;
      interceptFlag <= 1'b0;
    end else begin
      outValid      <= ctrl.capture;
      selLoad       <= ctrl.capture & ctrl.isFar;
      illegalFlag   <= inValid & ~legal;
      interceptFlag <= ctrl.capture & ctrl.isFar & protMode;
    end
  end

  // R2: a result strobe always traces back to an accepted input
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid));
  // R11: result and illegal strobes never coincide
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(outValid && illegalFlag));
  // R10: intercept only accompanies a far load
  a_r10_far_only: assert property (@(posedge clk) disable iff (rst)
    interceptFlag |-> (selLoad && outValid));
endmodule

// File: rtl/jtu_datapath.sv
module jtu_datapath
  import jtu_pkg::*;
#(
  parameter int IP_W  = 32,
  parameter int SEL_W = 16,
  parameter int LEN_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  jtuCtrl_t              ctrl,
  input  logic [IP_W+SEL_W-1:0] immBytes,
  input  logic [LEN_W-1:0]      instLen,
  input  logic [IP_W-1:0]       curIp,
  input  logic [IP_W+SEL_W-1:0] rmOperand,
  output logic [IP_W-1:0]       nextIp,
  output logic [SEL_W-1:0]      selOut
);
  localparam int HALF_W = IP_W / 2;
  localparam int PTR_W  = IP_W + SEL_W;

  logic [IP_W-1:0]  dispExt, followIp, relSum, absIp, farIp, rawIp, targetIp;
  logic [PTR_W-1:0] ptrSrc;
  logic [SEL_W-1:0] farSel;

  always_comb begin
    unique case (ctrl.dispSize)
      DISP_B8:  dispExt = {{(IP_W-8){immBytes[7]}}, immBytes[7:0]};
      DISP_B16: dispExt = {{(IP_W-16){immBytes[15]}}, immBytes[15:0]};
      default:  dispExt = immBytes[IP_W-1:0];
    endcase
    followIp = curIp + {{(IP_W-LEN_W){1'b0}}, instLen};
    relSum   = followIp + dispExt;
    absIp    = rmOperand[IP_W-1:0];

    ptrSrc = ctrl.fromImm ? immBytes : rmOperand;
    if (ctrl.wide) begin
      farIp  = ptrSrc[IP_W-1:0];
      farSel = ptrSrc[IP_W+SEL_W-1:IP_W];
    end else begin
      farIp  = {{(IP_W-HALF_W){1'b0}}, ptrSrc[HALF_W-1:0]};
      farSel = ptrSrc[HALF_W+SEL_W-1:HALF_W];
    end

    if (ctrl.isRel)      rawIp = relSum;
    else if (ctrl.isFar) rawIp = farIp;
    else                 rawIp = absIp;

    targetIp = ctrl.wide ? rawIp : {{(IP_W-HALF_W){1'b0}}, rawIp[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nextIp <= '0;
      selOut <= '0;
    end else if (ctrl.capture) begin
      nextIp <= targetIp;
      if (ctrl.isFar) selOut <= farSel;
    end
  end

  // R5: narrow operand size leaves the upper half clear
  a_r5_narrow_ip: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl.capture && !ctrl.wide) |-> (nextIp[IP_W-1:HALF_W] == '0));
  // R11: idle or rejected cycles leave the pointer alone
  a_r11_ip_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl.capture) |-> $stable(nextIp));
endmodule

// File: rtl/jump_target_unit.sv
module jump_target_unit
  import jtu_pkg::*;
#(
  parameter int IP_W  = 32,
  parameter int SEL_W = 16,
  parameter int LEN_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  input  logic [7:0]            opcode,
  input  logic [2:0]            modrmReg,
  input  logic [IP_W+SEL_W-1:0] immBytes,
  input  logic [LEN_W-1:0]      instLen,
  input  logic [IP_W-1:0]       curIp,
  input  logic                  opSize32,
  input  logic                  protMode,
  input  logic [IP_W+SEL_W-1:0] rmOperand,
  output logic [IP_W-1:0]       nextIp,
  output logic [SEL_W-1:0]      selOut,
  output logic                  selLoad,
  output logic                  outValid,
  output logic                  illegalFlag,
  output logic                  interceptFlag
);
  jtuCtrl_t ctrlBus;

  jtu_control ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opcode(opcode),
    .modrmReg(modrmReg), .opSize32(opSize32), .protMode(protMode),
    .ctrl(ctrlBus), .outValid(outValid), .selLoad(selLoad),
    .illegalFlag(illegalFlag), .interceptFlag(interceptFlag)
  );

  jtu_datapath #(.IP_W(IP_W), .SEL_W(SEL_W), .LEN_W(LEN_W)) dp_i (
    .clk(clk), .rst(rst), .ctrl(ctrlBus), .immBytes(immBytes),
    .instLen(instLen), .curIp(curIp), .rmOperand(rmOperand),
    .nextIp(nextIp), .selOut(selOut)
  );

  // R1: first cycle after reset shows cleared outputs
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && !selLoad && !illegalFlag && nextIp == '0 && selOut == '0));
  // R7: the selector moves only with a far load
  a_r7_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !selLoad |-> $stable(selOut));
  // R11: an illegal encoding changes neither result
  a_r11_illegal_hold: assert property (@(posedge clk) disable iff (rst)
    illegalFlag |-> ($stable(nextIp) && $stable(selOut)));
endmodule

// File: tb/jump_target_unit_tb_top.sv
module jump_target_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [7:0]  opcode;
  logic [2:0]  modrmReg;
  logic [47:0] immBytes;
  logic [3:0]  instLen;
  logic [31:0] curIp;
  logic        opSize32;
  logic        protMode;
  logic [47:0] rmOperand;
  logic [31:0] nextIp;
  logic [15:0] selOut;
  logic        selLoad, outValid, illegalFlag, interceptFlag;

  always #2.5 clk = ~clk;  // 200 MHz

  jump_target_unit dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opcode(opcode), .modrmReg(modrmReg),
    .immBytes(immBytes), .instLen(instLen), .curIp(curIp), .opSize32(opSize32),
    .protMode(protMode), .rmOperand(rmOperand), .nextIp(nextIp), .selOut(selOut),
    .selLoad(selLoad), .outValid(outValid), .illegalFlag(illegalFlag),
    .interceptFlag(interceptFlag)
  );

  typedef struct {
    int          due;
    logic        valid;
    logic        illegal;
    logic [31:0] ip;
    logic [15:0] sel;
    logic        selLd;
    logic        icpt;
    string       tag;
  } expItem_t;

  expItem_t   expQ[$];
  int         cycle = 0;
  int         checks = 0;
  int         fails = 0;
  logic [31:0] modelIp = '0;
  logic [15:0] modelSel = '0;

  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input string tag, input string what, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: apply one request and push its expected outcome
  task automatic send(input string tag, input logic [7:0] op, input logic [2:0] rg,
                      input logic [47:0] imm, input logic [3:0] len, input logic [31:0] ip,
                      input logic o32, input logic pm, input logic [47:0] rm);
    expItem_t e;
    logic [31:0] disp, r;
    logic isFar, legal;
    @(negedge clk);
    opcode = op; modrmReg = rg; immBytes = imm; instLen = len; curIp = ip;
    opSize32 = o32; protMode = pm; rmOperand = rm; inValid = 1'b1;
    legal = (op == 8'hEB) || (op == 8'hE9) || (op == 8'hEA) ||
            (op == 8'hFF && (rg == 3'd4 || rg == 3'd5));
    isFar = (op == 8'hEA) || (op == 8'hFF && rg == 3'd5);
    r = modelIp;
    if (op == 8'hEB) begin
      disp = {{24{imm[7]}}, imm[7:0]};
      r = ip + 32'(len) + disp;
    end else if (op == 8'hE9) begin
      disp = o32 ? imm[31:0] : {{16{imm[15]}}, imm[15:0]};
      r = ip + 32'(len) + disp;
    end else if (op == 8'hFF && rg == 3'd4) begin
      r = rm[31:0];
    end else if (isFar) begin
      logic [47:0] src;
      src = (op == 8'hEA) ? imm : rm;
      r = o32 ? src[31:0] : {16'h0, src[15:0]};
      modelSel = o32 ? src[47:32] : src[31:16];
    end
    if (legal && !o32) r[31:16] = 16'h0;
    if (legal) modelIp = r;
    e.due = cycle + 1;
    e.valid = legal; e.illegal = !legal;
    e.ip = modelIp; e.sel = modelSel;
    e.selLd = legal && isFar; e.icpt = legal && isFar && pm;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Monitor: compare at the falling edge of the due cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (expQ.size() != 0 && expQ[0].due == cycle) begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.tag, "outValid", 48'(outValid), 48'(e.valid));
        check(e.tag, "illegalFlag", 48'(illegalFlag), 48'(e.illegal));
        check(e.tag, "nextIp", 48'(nextIp), 48'(e.ip));
        check(e.tag, "selOut", 48'(selOut), 48'(e.sel));
        check(e.tag, "selLoad", 48'(selLoad), 48'(e.selLd));
        check(e.tag, "interceptFlag", 48'(interceptFlag), 48'(e.icpt));
      end else if (outValid || illegalFlag) begin
        check("R2", "unexpected strobe", 48'(1), 48'(0));
      end
    end
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; opcode = '0; modrmReg = '0; immBytes = '0;
    instLen = '0; curIp = '0; opSize32 = 1'b1; protMode = 1'b0; rmOperand = '0;
    repeat (3) @(negedge clk);
    // R1: cleared outputs during reset
    check("R1", "outValid", 48'(outValid), 48'(0));
    check("R1", "nextIp", 48'(nextIp), 48'(0));
    check("R1", "selOut", 48'(selOut), 48'(0));
    check("R1", "flags", 48'({selLoad, illegalFlag, interceptFlag}), 48'(0));
    rst = 1'b0;
    // R3 forward and backward short displacement
    send("R3_fwd", 8'hEB, 3'd0, 48'h10, 4'd2, 32'h0000_1000, 1'b1, 1'b0, 48'h0);
    send("R3_back", 8'hEB, 3'd0, 48'hF0, 4'd2, 32'h0000_1000, 1'b1, 1'b0, 48'h0);
    idle();
    // R4 wide and narrow near displacement, R5 upper half cleared
    send("R4_w32", 8'hE9, 3'd0, 48'h0001_2345, 4'd5, 32'h0000_4000, 1'b1, 1'b0, 48'h0);
    send("R4_R5_w16", 8'hE9, 3'd0, 48'hFFFE, 4'd3, 32'h1234_0100, 1'b0, 1'b0, 48'h0);
    // R12 wrap in 32 and 16 bits
    send("R12_wrap32", 8'hEB, 3'd0, 48'h20, 4'd2, 32'hFFFF_FFF0, 1'b1, 1'b0, 48'h0);
    send("R12_wrap16", 8'hE9, 3'd0, 48'h0020, 4'd3, 32'h1234_FFF0, 1'b0, 1'b0, 48'h0);
    idle();
    // R6 near indirect, R7 selector untouched
    send("R6_R7_ind32", 8'hFF, 3'd4, 48'h0, 4'd2, 32'h100, 1'b1, 1'b1, 48'hAAAA_DEAD_BEEF);
    send("R6_R5_ind16", 8'hFF, 3'd4, 48'h0, 4'd2, 32'h100, 1'b0, 1'b0, 48'hAAAA_DEAD_BEEF);
    // R8 far immediate, wide and narrow, R10 intercept on/off
    send("R8_R10_imm32", 8'hEA, 3'd0, 48'h0123_89AB_CDEF, 4'd7, 32'h200, 1'b1, 1'b0, 48'h0);
    send("R8_R10_imm16", 8'hEA, 3'd0, 48'hFFFF_0456_7777, 4'd5, 32'h200, 1'b0, 1'b1, 48'h0);
    idle();
    // R7 near after far keeps selector
    send("R7_after_far", 8'hEB, 3'd0, 48'h04, 4'd2, 32'h300, 1'b1, 1'b1, 48'h0);
    // R9 far through memory pointer
    send("R9_mem32", 8'hFF, 3'd5, 48'h0, 4'd2, 32'h400, 1'b1, 1'b1, 48'h0789_0040_0000);
    send("R9_mem16", 8'hFF, 3'd5, 48'h0, 4'd2, 32'h400, 1'b0, 1'b0, 48'hCCCC_0ABC_1234);
    // R11 illegal encodings hold state
    send("R11_ff_reg2", 8'hFF, 3'd2, 48'h0, 4'd2, 32'h500, 1'b1, 1'b1, 48'h1111_2222_3333);
    send("R11_opcode", 8'h90, 3'd0, 48'h55, 4'd1, 32'h600, 1'b1, 1'b1, 48'h0);
    send("R11_ff_reg7", 8'hFF, 3'd7, 48'h0, 4'd2, 32'h700, 1'b0, 1'b0, 48'h9999_8888_7777);
    send("R3_after_illegal", 8'hEB, 3'd0, 48'h7F, 4'd2, 32'h0000_8000, 1'b1, 1'b0, 48'h0);
    idle();
    repeat (4) @(negedge clk);
    check("R2", "pending results", 48'(expQ.size()), 48'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule